// File: doc/BRIEF.md
# Reload Event Counter with Overflow Flag

This block counts falling edges on an external pin whose transitions have no phase relation to the system clock. The pin passes through a multi-flop synchronizer, and edges are detected in the system clock domain, so each falling edge yields at most one count. The count is an up-counter. When it steps past its all-ones value it does not land on zero. Instead it is reloaded from a programmable reload value, and a sticky overflow flag is raised that stays set until it is explicitly cleared.

Counting happens only in event mode, which means the enable is high and the clock-source select chooses the external pin. Each time the enable goes high, the count is preloaded from the reload value. While event mode is active, the block forces the pin's general wake-up request and the pin's interrupt request to inactive. This keeps the counted signal from waking the system or raising pin interrupts. Outside event mode, both requests pass through unchanged from the pin logic that produces them.

Top module: `evtcnt_top`

## Requirements
- R1: While reset is high and in the first cycle after reset, `count` is 0 and `ovf_flag` is 0.
- R2: In event mode (`cnt_en`=1 and `src_ext`=1), every falling edge on `pin_raw` adds one to `count`. This holds when each level is held for at least 3 clock cycles. Rising edges leave `count` unchanged.
- R3: A counted falling edge that arrives while `count` is 0xFF loads `count` with `reload_val` instead of 0 and sets `ovf_flag`.
- R4: `ovf_flag` stays at 1 until a cycle with `flag_clr`=1. In the cycle after that strobe, the flag reads 0.
- R5: If an overflow and `flag_clr` fall in the same cycle, `ovf_flag` is 1 afterwards.
- R6: In the cycle after `cnt_en` goes from 0 to 1, `count` equals `reload_val`.
- R7: While `cnt_en`=0, or while `src_ext`=0 (internal source selected), falling edges on `pin_raw` do not change `count`, and `count` holds its value.
- R8: `wake_req` is 0 in event mode. Otherwise it equals `gpio_wake_in`.
- R9: `pin_irq` is 0 in event mode. Otherwise it equals `gpio_irq_in`.
- R10: A single low period on `pin_raw` of any length of at least 3 cycles counts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external event pin |
| cnt_en | input | 1 | Counter enable; a rising edge preloads the count |
| src_ext | input | 1 | Clock-source select, 1 = external pin, 0 = internal |
| reload_val | input | 8 | Reload value used at enable and on wrap |
| flag_clr | input | 1 | One-cycle strobe that clears the overflow flag |
| gpio_wake_in | input | 1 | Wake-up request from the pin logic |
| gpio_irq_in | input | 1 | Interrupt request from the pin logic |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| wake_req | output | 1 | Wake-up request after event-mode masking |
| pin_irq | output | 1 | Pin interrupt request after event-mode masking |

## Verification
Directed runs cover several pin waveforms:
- Short pulses walk the count from a preload up through 0xFF and the wrap. This separates a true reload from a plain roll to zero.
- A long low period shows whether the edge detector counts a level or an edge.
- Pulses applied with the enable low, or with the internal source selected, expose any leak of counting outside event mode.
- An overflow lined up with a clear strobe tells set priority apart from clear priority.

A random mix of pulse lengths, reload changes, source toggles and clears is then compared against a reference model in the bench. Both mask outputs are checked under each combination of mode and request input.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

    localparam int CNT_W_DEF  = 8;
    localparam int SYNC_N_DEF = 2;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_INT = 2'd1,
        MODE_EVT = 2'd2
    } cnt_mode_e;

    function automatic cnt_mode_e decode_mode(input logic en, input logic ext);
        if (!en)     return MODE_OFF;
        else if (ext) return MODE_EVT;
        else         return MODE_INT;
    endfunction

    typedef struct packed {
        logic step;
        logic load;
        logic clr;
    } core_ctl_t;

endpackage

// File: rtl/evtcnt_edge.sv
module evtcnt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b1;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];

    // one count per edge
    p_single_fall_r10: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core
    import evtcnt_pkg::*;
#(
    parameter int WIDTH = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  core_ctl_t        ctl,
    input  logic [WIDTH-1:0] reload,
    output logic [WIDTH-1:0] count,
    output logic             flag
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    logic at_top;
    logic wrap;

    assign at_top = (count == TOP_VAL);
    assign wrap   = ctl.step && !ctl.load && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (ctl.load || wrap) begin
            count <= reload;
        end else if (ctl.step) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (ctl.clr)  flag <= 1'b0;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.load && !at_top) |=> count == WIDTH'($past(count) + 1'b1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.load && at_top) |=> (count == $past(reload)) && flag);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !ctl.clr) |=> flag);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (wrap && ctl.clr) |=> flag);

    p_preload_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> count == $past(reload));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.step && !ctl.load) |=> $stable(count));

endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
    import evtcnt_pkg::*;
#(
    parameter int WIDTH  = CNT_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_raw,
    input  logic             cnt_en,
    input  logic             src_ext,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             flag_clr,
    input  logic             gpio_wake_in,
    input  logic             gpio_irq_in,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag,
    output logic             wake_req,
    output logic             pin_irq
);
    cnt_mode_e mode;
    logic      fall;
    logic      en_q;
    core_ctl_t ctl;

    assign mode = decode_mode(cnt_en, src_ext);

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= cnt_en;
    end

    evtcnt_edge #(.STAGES(SYNC_N)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_raw),
        .fall      (fall)
    );

    always_comb begin
        ctl.load = cnt_en && !en_q;
        ctl.step = (mode == MODE_EVT) && fall;
        ctl.clr  = flag_clr;
    end

    evtcnt_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .reload (reload_val),
        .count  (count),
        .flag   (ovf_flag)
    );

    assign wake_req = (mode == MODE_EVT) ? 1'b0 : gpio_wake_in;
    assign pin_irq  = (mode == MODE_EVT) ? 1'b0 : gpio_irq_in;

    p_wake_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && src_ext) |-> !wake_req);

    p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && src_ext) |-> !pin_irq);

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (count == '0) && !ovf_flag);

endmodule

// File: tb/tb_evtcnt_top.sv
module tb_evtcnt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_raw = 1'b1;
    logic       cnt_en = 1'b0;
    logic       src_ext = 1'b0;
    logic [7:0] reload_val = 8'h00;
    logic       flag_clr = 1'b0;
    logic       gpio_wake_in = 1'b0;
    logic       gpio_irq_in = 1'b0;
    logic [7:0] count;
    logic       ovf_flag;
    logic       wake_req;
    logic       pin_irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_cnt;
    logic       exp_flag;

    always #10 clk = ~clk;

    evtcnt_top dut (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .cnt_en(cnt_en),
        .src_ext(src_ext), .reload_val(reload_val), .flag_clr(flag_clr),
        .gpio_wake_in(gpio_wake_in), .gpio_irq_in(gpio_irq_in),
        .count(count), .ovf_flag(ovf_flag), .wake_req(wake_req), .pin_irq(pin_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] model_next(input logic [7:0] c, input logic [7:0] r);
        return (c == 8'hFF) ? r : c + 8'd1;
    endfunction

    task automatic pulse(input int lo, input int hi);
        pin_raw = 1'b0;
        wait_n(lo);
        pin_raw = 1'b1;
        wait_n(hi);
        if (cnt_en && src_ext) begin
            if (exp_cnt == 8'hFF) exp_flag = 1'b1;
            exp_cnt = model_next(exp_cnt, reload_val);
        end
    endtask

    task automatic check_masks(input string req);
        for (int k = 0; k < 4; k++) begin
            gpio_wake_in = k[0];
            gpio_irq_in  = k[1];
            #1;
            if (req == "R8")
                check("R8", {7'd0, wake_req}, {7'd0, (cnt_en && src_ext) ? 1'b0 : k[0]});
            else
                check("R9", {7'd0, pin_irq}, {7'd0, (cnt_en && src_ext) ? 1'b0 : k[1]});
        end
        gpio_wake_in = 1'b0;
        gpio_irq_in  = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_n(3);
        check("R1", count, 8'h00);
        check("R1", {7'd0, ovf_flag}, 8'h00);
        rst = 1'b0;
        wait_n(1);
        check("R1", count, 8'h00);
        check("R1", {7'd0, ovf_flag}, 8'h00);
        exp_cnt = 8'h00; exp_flag = 1'b0;

        // masks outside event mode
        check_masks("R8");
        check_masks("R9");

        // R7: enable low, pulses do not count
        src_ext = 1'b1;
        pulse(3, 3); pulse(4, 4);
        exp_cnt = 8'h00;
        check("R7", count, exp_cnt);

        // R6: preload on enable
        reload_val = 8'hF0;
        cnt_en = 1'b1;
        wait_n(1);
        exp_cnt = 8'hF0;
        check("R6", count, 8'hF0);
        check_masks("R8");
        check_masks("R9");

        // R2: walk up to FF
        for (int i = 0; i < 15; i++) begin
            pulse(3, 3);
            check("R2", count, exp_cnt);
        end
        check("R2", count, 8'hFF);
        check("R2", {7'd0, ovf_flag}, 8'h00);

        // R3: wrap reloads and sets flag
        reload_val = 8'h3C;
        pulse(3, 3);
        check("R3", count, 8'h3C);
        check("R3", {7'd0, ovf_flag}, 8'h01);

        // R4: sticky then clear
        wait_n(5);
        check("R4", {7'd0, ovf_flag}, 8'h01);
        flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
        exp_flag = 1'b0;
        check("R4", {7'd0, ovf_flag}, 8'h00);

        // R10: long low period counts once
        pulse(25, 3);
        check("R10", count, 8'h3D);

        // R7: internal source selected
        src_ext = 1'b0;
        check_masks("R8");
        check_masks("R9");
        pulse(3, 3); pulse(5, 3);
        check("R7", count, 8'h3D);
        src_ext = 1'b1;
        wait_n(1);

        // R5: overflow coincides with clear
        cnt_en = 1'b0; wait_n(1);
        reload_val = 8'hFF; cnt_en = 1'b1; wait_n(1);
        exp_cnt = 8'hFF;
        check("R6", count, 8'hFF);
        reload_val = 8'h10;
        pin_raw = 1'b0;
        wait_n(2);
        flag_clr = 1'b1;
        wait_n(1);
        flag_clr = 1'b0;
        wait_n(1);
        pin_raw = 1'b1;
        wait_n(3);
        exp_cnt = 8'h10; exp_flag = 1'b1;
        check("R5", {7'd0, ovf_flag}, 8'h01);
        check("R3", count, 8'h10);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int act;
            act = $urandom_range(0, 9);
            if (act < 6) begin
                pulse($urandom_range(3, 7), $urandom_range(3, 6));
                check("R2", count, exp_cnt);
                check("R3", {7'd0, ovf_flag}, {7'd0, exp_flag});
            end else if (act == 6) begin
                reload_val = ($urandom_range(0, 1) == 1) ? 8'hFE : 8'($urandom);
            end else if (act == 7) begin
                flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
                exp_flag = 1'b0;
                check("R4", {7'd0, ovf_flag}, 8'h00);
            end else if (act == 8) begin
                src_ext = ~src_ext;
                wait_n(1);
                check("R7", count, exp_cnt);
            end else begin
                cnt_en = 1'b0; wait_n(2);
                check("R7", count, exp_cnt);
                cnt_en = 1'b1; wait_n(1);
                exp_cnt = reload_val;
                check("R6", count, exp_cnt);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule